// File: doc/BRIEF.md
# Streaming 7x7 Symmetric Convolution Filter

This block filters a raster-ordered pixel stream with a 7x7 two-dimensional kernel. It accepts one pixel per clock and returns one filtered sample for every pixel it accepts. Inside, a grid of 7 rows by 7 registers always holds the current neighbourhood. Each row is linked to the next by a RAM-based line delay, so a row of registers and its delay together span one image line of `LINE_W` pixels. The block can serve as a smoothing pre-filter or as the numerator or denominator filter of a ratio. Only the coefficient set changes between these uses.

The kernel must have eightfold symmetry. Taps that share a coefficient are summed before they are multiplied, so one window needs ten multipliers. The ten coefficients are signed and are written through a small port while the stream is idle. The stream moves forward on every clock. A cycle without a valid pixel enters the grid as a zero pixel, which keeps the geometry of the raster intact. The result leaves the block a fixed number of clocks later, together with a delayed copy of the input strobe. The caller decides how to handle image borders. The grid only holds defined data once 6*`LINE_W`+10 clocks have passed since reset, so the first valid pixel must come after that.

Top module: `conv7_stream`

## Requirements
- R1: While `pix_valid` is low, the value on `pix_data` has no effect. That cycle enters the grid as a zero pixel, and the grid still shifts by one position.
- R2: Let x(t) be the pixel accepted at clock edge t, taken as two's complement, with zero on invalid cycles. The output for the pixel accepted at edge e is the sum over dr, dc in -3..3 of K(dr,dc)·x(e + dr·LINE_W + dc).
- R3: K(dr,dc) is the coefficient at address i·(i+1)/2 + j, where i = max(|dr|,|dc|) and j = min(|dr|,|dc|). The valid addresses are 0 to 9, and address 0 is the centre tap.
- R4: `out_valid` rises and `out_data` is updated exactly 3·LINE_W+7 edges after the edge that accepts the pixel. That is 1207 edges for a 400-pixel line.
- R5: Every accepted pixel produces exactly one cycle with `out_valid` high. `out_valid` is never high for any other reason.
- R6: A synchronous reset clears `out_valid`, `out_data` and all ten coefficients to zero.
- R7: A coefficient write with `coef_we` high at an edge takes effect for every output that is updated two or more edges later. The coefficient keeps its value until it is overwritten.
- R8: The result is exact for every pixel and coefficient in range, with no overflow or wrap. It is `PIX_W+COEF_W+7` bits wide, so an all-minimum window times all-minimum coefficients gives the exact positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Signed pixel |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 4 | Coefficient class address, 0 to 9 |
| coef_data | input | COEF_W | Signed coefficient |
| out_valid | output | 1 | Filtered sample strobe |
| out_data | output | PIX_W+COEF_W+7 | Signed filtered sample |

## Verification
The properties assume the caller writes only to addresses 0 to 9. They also assume that no pixel is lost or duplicated, so a count of accepted pixels minus emitted samples never goes negative and never exceeds the depth of the pipeline. The stimulus changes coefficients only on idle stretches that are longer than the latency. It streams pixels only after the grid has been filled with zeros following reset, so every expected sample is fully determined. The random pixels include many extreme values, and one phase uses full-scale negative values throughout, to reach the largest accumulator magnitude.

// File: rtl/conv7_pkg.sv
package conv7_pkg;

    localparam int KSZ         = 7;
    localparam int HALF        = KSZ / 2;
    localparam int NCLS        = (HALF + 1) * (HALF + 2) / 2;
    localparam int PIPE_STAGES = 3;
    localparam int CADDR_W     = 4;

    typedef enum logic [1:0] {
        ST_PREADD = 2'd0,
        ST_MULT   = 2'd1,
        ST_SUM    = 2'd2
    } mac_stage_e;

    // Symmetry class of a grid position (row, col in 0..KSZ-1)
    function automatic int tap_class(int r, int c);
        int a, b, hi, lo;
        a  = (r > HALF) ? r - HALF : HALF - r;
        b  = (c > HALF) ? c - HALF : HALF - c;
        hi = (a > b) ? a : b;
        lo = (a > b) ? b : a;
        return hi * (hi + 1) / 2 + lo;
    endfunction

    // Edges from pixel acceptance to result update
    function automatic int pipe_latency(int line_w);
        return HALF * line_w + HALF + 1 + PIPE_STAGES;
    endfunction

    function automatic int pre_width(int pix_w);
        return pix_w + 3;
    endfunction

    function automatic int acc_width(int pix_w, int coef_w);
        return pre_width(pix_w) + coef_w + CADDR_W;
    endfunction

endpackage

// File: rtl/conv7_line_fifo.sv
module conv7_line_fifo #(
    parameter int DEPTH = 393,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;

    // Read before overwrite: each slot returns what it held DEPTH edges ago
    assign q = mem[ptr];

    always_ff @(posedge clk) begin
        mem[ptr] <= d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (ptr == PW'(DEPTH - 1))
            ptr <= '0;
        else
            ptr <= ptr + 1'b1;
    end

endmodule

// File: rtl/conv7_window.sv
module conv7_window
    import conv7_pkg::*;
#(
    parameter int LINE_W = 400,
    parameter int PIX_W  = 10
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [PIX_W-1:0]                        din,
    output logic [KSZ-1:0][KSZ-1:0][PIX_W-1:0]      win
);
    localparam int GAP = LINE_W - KSZ;

    logic [KSZ-1:0][PIX_W-1:0] row_in;

    assign row_in[0] = din;

    for (genvar r = 0; r < KSZ; r++) begin : g_row
        logic [KSZ-1:0][PIX_W-1:0] sh;

        always_ff @(posedge clk) begin
            if (rst)
                sh <= '0;
            else
                sh <= {sh[KSZ-2:0], row_in[r]};
        end

        assign win[r] = sh;

        if (r < KSZ - 1) begin : g_link
            logic [PIX_W-1:0] fq;
            conv7_line_fifo #(.DEPTH(GAP), .W(PIX_W)) u_line (
                .clk (clk),
                .rst (rst),
                .d   (sh[KSZ-1]),
                .q   (fq)
            );
            assign row_in[r+1] = fq;
        end
    end

endmodule

// File: rtl/conv7_mac.sv
module conv7_mac
    import conv7_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int COEF_W = 10
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [KSZ-1:0][KSZ-1:0][PIX_W-1:0]  win,
    input  logic [NCLS-1:0][COEF_W-1:0]         coef,
    output logic [acc_width(PIX_W, COEF_W)-1:0] acc
);
    localparam int PRE_W  = pre_width(PIX_W);
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int ACC_W  = acc_width(PIX_W, COEF_W);

    logic signed [PRE_W-1:0]  pre_n [NCLS];
    logic signed [PRE_W-1:0]  pre_q [NCLS];
    logic signed [PROD_W-1:0] prod_q [NCLS];
    logic signed [ACC_W-1:0]  acc_n;
    logic signed [ACC_W-1:0]  acc_q;

    // ST_PREADD: fold taps sharing a coefficient
    always_comb begin
        for (int k = 0; k < NCLS; k++) pre_n[k] = '0;
        for (int r = 0; r < KSZ; r++) begin
            for (int c = 0; c < KSZ; c++) begin
                pre_n[tap_class(r, c)] = pre_n[tap_class(r, c)]
                                       + PRE_W'($signed(win[r][c]));
            end
        end
    end

    for (genvar k = 0; k < NCLS; k++) begin : g_cls
        always_ff @(posedge clk) begin
            if (rst) begin
                pre_q[k]  <= '0;
                prod_q[k] <= '0;
            end else begin
                pre_q[k]  <= pre_n[k];
                // ST_MULT
                prod_q[k] <= PROD_W'(pre_q[k]) * PROD_W'($signed(coef[k]));
            end
        end
    end

    // ST_SUM
    always_comb begin
        acc_n = '0;
        for (int k = 0; k < NCLS; k++) acc_n = acc_n + ACC_W'(prod_q[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_n;
    end

    assign acc = acc_q;

endmodule

// File: rtl/conv7_stream.sv
module conv7_stream
    import conv7_pkg::*;
#(
    parameter int LINE_W = 400,
    parameter int PIX_W  = 10,
    parameter int COEF_W = 10
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                pix_valid,
    input  logic [PIX_W-1:0]                    pix_data,
    input  logic                                coef_we,
    input  logic [CADDR_W-1:0]                  coef_addr,
    input  logic [COEF_W-1:0]                   coef_data,
    output logic                                out_valid,
    output logic [acc_width(PIX_W, COEF_W)-1:0] out_data
);
    localparam int LAT   = pipe_latency(LINE_W);
    localparam int ACC_W = acc_width(PIX_W, COEF_W);

    logic                               vld_q;
    logic [PIX_W-1:0]                   pix_q;
    logic [LAT-1:0]                     vsr;
    logic [NCLS-1:0][COEF_W-1:0]        coef_q;
    logic [KSZ-1:0][KSZ-1:0][PIX_W-1:0] win;
    logic [ACC_W-1:0]                   acc;

    // Input register: idle cycles become zero pixels
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            pix_q <= '0;
        end else begin
            vld_q <= pix_valid;
            pix_q <= pix_valid ? pix_data : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            coef_q <= '0;
        else if (coef_we && (int'(coef_addr) < NCLS))
            coef_q[coef_addr] <= coef_data;
    end

    // Strobe follows the data through an equal-length delay
    always_ff @(posedge clk) begin
        if (rst) vsr <= '0;
        else     vsr <= {vsr[LAT-2:0], vld_q};
    end

    conv7_window #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_win (
        .clk (clk),
        .rst (rst),
        .din (pix_q),
        .win (win)
    );

    conv7_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_mac (
        .clk  (clk),
        .rst  (rst),
        .win  (win),
        .coef (coef_q),
        .acc  (acc)
    );

    assign out_valid = vsr[LAT-1];
    assign out_data  = acc;

endmodule

// File: rtl/conv7_chk.sv
module conv7_chk
    import conv7_pkg::*;
#(
    parameter int LINE_W = 400
) (
    input logic               clk,
    input logic               rst,
    input logic               pix_valid,
    input logic               coef_we,
    input logic [CADDR_W-1:0] coef_addr,
    input logic               out_valid
);
    localparam int LAT = pipe_latency(LINE_W);
    localparam int CW  = $clog2(LAT + 4) + 1;

    logic [CW-1:0] pending;
    logic [CW-1:0] since_rst;
    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= '0;
            since_rst <= '0;
            idle_cnt  <= CW'(LAT + 2);
        end else begin
            pending   <= pending + CW'(pix_valid) - CW'(out_valid);
            if (since_rst < CW'(LAT + 2)) since_rst <= since_rst + 1'b1;
            if (pix_valid)                    idle_cnt <= '0;
            else if (idle_cnt < CW'(LAT + 2)) idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R5
    out_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pending != '0));

    // R5
    pending_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pending <= CW'(LAT + 1));

    // R6
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst <= CW'(LAT)) |-> !out_valid);

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt > CW'(LAT)) |-> !out_valid);

    // R3
    coef_addr_chk: assert property (@(posedge clk) disable iff (rst)
        coef_we |-> (int'(coef_addr) < NCLS));

endmodule

bind conv7_stream conv7_chk #(.LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .coef_we   (coef_we),
    .coef_addr (coef_addr),
    .out_valid (out_valid)
);

// File: tb/tb_conv7_stream.sv
module tb_conv7_stream;
    localparam int L     = 400;
    localparam int PW    = 10;
    localparam int CW    = 10;
    localparam int AW    = PW + CW + 7;
    localparam int LAT   = 3 * L + 7;
    localparam int NSTEP = 13000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pix_valid = 1'b0;
    logic [PW-1:0] pix_data = '0;
    logic          coef_we = 1'b0;
    logic [3:0]    coef_addr = '0;
    logic [CW-1:0] coef_data = '0;
    logic          out_valid;
    logic [AW-1:0] out_data;

    int  s_val [NSTEP];
    bit  s_vld [NSTEP];
    int  s_bank[NSTEP];
    int  kbank [2][10];
    int  step = 0;
    int  bank = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    int  n_in = 0;
    int  n_out = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    conv7_stream #(.LINE_W(L), .PIX_W(PW), .COEF_W(CW)) dut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int cls_of(int dr, int dc);
        int a, b, hi, lo;
        a  = (dr < 0) ? -dr : dr;
        b  = (dc < 0) ? -dc : dc;
        hi = (a > b) ? a : b;
        lo = (a > b) ? b : a;
        return hi * (hi + 1) / 2 + lo;
    endfunction

    function automatic int pix_at(int idx);
        if (idx < 0 || idx >= step) return 0;
        return s_val[idx];
    endfunction

    // R2 R3: reference sum for the pixel accepted at step n
    function automatic int model(int n);
        int acc = 0;
        for (int dr = -3; dr <= 3; dr++)
            for (int dc = -3; dc <= 3; dc++)
                acc += kbank[s_bank[n]][cls_of(dr, dc)] * pix_at(n + dr * L + dc);
        return acc;
    endfunction

    task automatic check_out();
        bit exp_v;
        int n, got, exp_d;
        n     = step - LAT - 1;
        exp_v = (n >= 0) ? s_vld[n] : 1'b0;
        n_chk++;
        if (out_valid !== exp_v) begin
            n_bad++;
            $display("FAIL R4 R5 step %0d: out_valid %0b expected %0b", step, out_valid, exp_v);
        end
        if (out_valid === 1'b1) n_out++;
        if (exp_v && out_valid === 1'b1) begin
            got   = int'($signed(out_data));
            exp_d = model(n);
            n_chk++;
            if (got != exp_d) begin
                n_bad++;
                $display("FAIL R2 R8 pixel %0d: out_data %0d expected %0d", n, got, exp_d);
            end
        end
    endtask

    // One stream step: check the previous edge, then drive the next
    task automatic do_step(bit v, int d, bit we, int addr, int cdat);
        @(negedge clk);
        check_out();
        pix_valid = v;
        pix_data  = v ? PW'(d) : PW'($urandom);  // R1: junk on idle cycles
        coef_we   = we;
        coef_addr = 4'(addr);
        coef_data = CW'(cdat);
        s_val[step]  = v ? d : 0;
        s_vld[step]  = v;
        s_bank[step] = bank;
        if (v) n_in++;
        step++;
    endtask

    task automatic load_bank(int b);
        bank = b;
        for (int k = 0; k < 10; k++) do_step(1'b0, 0, 1'b1, k, kbank[b][k]);  // R7
        do_step(1'b0, 0, 1'b0, 0, 0);
    endtask

    task automatic idle(int cnt);
        for (int i = 0; i < cnt; i++) do_step(1'b0, 0, 1'b0, 0, 0);
    endtask

    function automatic int rand_pix();
        int sel;
        sel = int'($urandom_range(7, 0));
        if (sel == 0) return -512;
        if (sel == 1) return 511;
        return int'($urandom_range(1023, 0)) - 512;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 10; k++) begin
            kbank[0][k] = int'($urandom_range(1023, 0)) - 512;
            kbank[1][k] = -512;
        end
        kbank[0][0] = 511;
        kbank[0][9] = -512;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R6
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_bad++;
            $display("FAIL R6: out_valid %0b out_data %0d expected 0 0", out_valid, out_data);
        end

        load_bank(0);
        idle(6 * L + 20);
        // R1 R2 R3: random stream with gaps and extreme values
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99, 0) < 85) do_step(1'b1, rand_pix(), 1'b0, 0, 0);
            else                            do_step(1'b0, 0, 1'b0, 0, 0);
        end
        idle(LAT + 20);

        // R7 R8: new full-scale negative coefficients, full-scale pixels
        load_bank(1);
        for (int i = 0; i < 2000; i++)
            do_step(1'b1, (i < 1500) ? -512 : ((i % 2 == 0) ? 511 : -512), 1'b0, 0, 0);
        idle(LAT + 20);

        // R5: one output per accepted pixel
        n_chk++;
        if (n_out != n_in) begin
            n_bad++;
            $display("FAIL R5: %0d outputs expected %0d", n_out, n_in);
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete at step %0d expected %0d", step, NSTEP);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule